// File: doc/BRIEF.md
# Crosspoint Output Round-Robin Arbiter

This block decides, once per word clock, which input of a 16-port crosspoint switch is connected to each output. Every input offers a request vector with one bit per output. A single set bit is a unicast request, several set bits a multicast request. Every input also drives a break flag. Every output has an out-of-sync flag. The block returns a grant matrix two word clocks after the requests are presented. Port logic can therefore learn the result before the switch changes.

Each grant result also enters a delay pipeline. The crossbar configuration (a select index and a valid bit per output) is loaded a programmable number D of word clocks after the result appears. A port card can place its request D words before the end of a packet, and its connection is then ready when the next packet starts. Every clock cycle is one word clock.

Top module: `xbar_rr_arb`

## Requirements
- R1: A synchronous active-high reset clears every grant, every configuration valid bit and every configuration select. It sets every output's priority pointer to input 0 and empties the delay pipeline.
- R2: Requests present before clock edge k show up on the grant outputs after edge k+1, which is two word clocks from request to result.
- R3: Each output keeps its own round-robin pointer. The search for a winner starts at the pointer and wraps upward. After input w wins through this search, the pointer moves to w+1 modulo 16, so w becomes that output's lowest priority.
- R4: An output is granted only to an input that requested it two edges earlier. Grant bit i*16+o means input i holds output o. Request bit i*16+o means input i asks for output o.
- R5: If the current holder of an output still requests it and its break flag is low, the holder keeps the output and the pointer is unchanged.
- R6: If the holder's break flag is high, the output goes to round-robin arbitration among all its requesters.
- R7: An output flagged out of sync is granted whenever any input requests it. The lowest-numbered requester wins, this overrides holding, and the pointer is unchanged.
- R8: An output with no requester is granted to nobody, its pointer is unchanged, and its configuration keeps the previous connection.
- R9: The configuration of output o loads the result determined D edges earlier, but only if that result was a grant. The select for output o is at bits o*4 to o*4+3 of the configuration select bus, and its valid bit is cfgValid[o].
- R10: D is a 4-bit input with a legal range of 2 to 15. Back-to-back results are applied in order, with none lost.
- R11: A multicast request may win several outputs in the same decision, each output arbitrated on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| reqFlat | input | 256 | Request matrix, bit i*16+o = input i wants output o |
| brkIn | input | 16 | Break flag per input |
| oosIn | input | 16 | Out-of-sync flag per output port |
| delayD | input | 4 | Configuration delay D in word clocks (2 to 15) |
| grantFlat | output | 256 | Grant matrix, bit i*16+o = input i holds output o |
| cfgValid | output | 16 | Output has a configured connection |
| cfgSelFlat | output | 64 | Selected input per output, 4 bits per output |

## Verification
The bench rotates three inputs over one output and checks that the grant moves upward and wraps. A pointer that failed to advance would grant the same input every time. Multicast holding with the break flag low and then high is checked next. A design that ignored the break flag would never release a held output, or would never keep one. Out-of-sync outputs with several requesters are exercised, where a design that arbitrated normally would pick the wrong input or disturb the pointer. Random traffic runs at D of 2, 8 and 15 and exposes off-by-one pipeline taps. Quiet stretches expose configurations that are wrongly cleared when no input requests an output.

// File: rtl/xbarArbPkg.sv
package xbarArbPkg;
  localparam int NPORT = 16;
  localparam int IDXW = $clog2(NPORT);
  localparam int NREQ = NPORT * NPORT;
  localparam int DLYW = 4;
  localparam int DLYMAX = (1 << DLYW) - 1;
  localparam int SRDEPTH = DLYMAX - 1;

  typedef struct packed {
    logic [NPORT-1:0] load;
    logic [NPORT-1:0][IDXW-1:0] sel;
  } arbStrobe_t;
endpackage

// File: rtl/xbarArbCtl.sv
module xbarArbCtl
  import xbarArbPkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] reqFlat,
  input  logic [NPORT-1:0] brkIn,
  input  logic [NPORT-1:0] oosIn,
  output arbStrobe_t      strobe,
  output logic [NREQ-1:0] grantFlat
);
  logic [NREQ-1:0]  reqQ;
  logic [NPORT-1:0] brkQ;
  logic [NPORT-1:0] oosQ;
  logic [NPORT-1:0] gVal;
  logic [IDXW-1:0]  gIdx [NPORT];
  logic [IDXW-1:0]  ptr  [NPORT];

  logic [NPORT-1:0] colVec [NPORT];
  logic [IDXW-1:0]  lowIdx [NPORT];
  logic [IDXW-1:0]  rrIdx  [NPORT];
  logic [NPORT-1:0] nVal;
  logic [IDXW-1:0]  nIdx [NPORT];
  logic [IDXW-1:0]  nPtr [NPORT];

  always_comb begin
    for (int o = 0; o < NPORT; o++)
      for (int i = 0; i < NPORT; i++)
        colVec[o][i] = reqQ[i*NPORT+o];
  end

  // lowest requester and round-robin candidate per output
  always_comb begin
    logic hit;
    logic [IDXW-1:0] cand;
    for (int o = 0; o < NPORT; o++) begin
      lowIdx[o] = '0;
      for (int k = NPORT-1; k >= 0; k--)
        if (colVec[o][k]) lowIdx[o] = IDXW'(k);
      rrIdx[o] = ptr[o];
      hit = 1'b0;
      for (int k = 0; k < NPORT; k++) begin
        cand = ptr[o] + IDXW'(k);
        if (!hit && colVec[o][cand]) begin
          rrIdx[o] = cand;
          hit = 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      nVal[o] = 1'b0;
      nIdx[o] = gIdx[o];
      nPtr[o] = ptr[o];
      if (oosQ[o] && |colVec[o]) begin
        nVal[o] = 1'b1;
        nIdx[o] = lowIdx[o];
      end else if (gVal[o] && colVec[o][gIdx[o]] && !brkQ[gIdx[o]]) begin
        nVal[o] = 1'b1;
      end else if (|colVec[o]) begin
        nVal[o] = 1'b1;
        nIdx[o] = rrIdx[o];
        nPtr[o] = rrIdx[o] + IDXW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reqQ <= '0;
      brkQ <= '0;
      oosQ <= '0;
      gVal <= '0;
      for (int o = 0; o < NPORT; o++) begin
        gIdx[o] <= '0;
        ptr[o]  <= '0;
      end
    end else begin
      reqQ <= reqFlat;
      brkQ <= brkIn;
      oosQ <= oosIn;
      gVal <= nVal;
      for (int o = 0; o < NPORT; o++) begin
        gIdx[o] <= nIdx[o];
        ptr[o]  <= nPtr[o];
      end
    end
  end

  always_comb begin
    strobe.load = gVal;
    for (int o = 0; o < NPORT; o++) strobe.sel[o] = gIdx[o];
  end

  for (genvar gi = 0; gi < NPORT; gi++) begin : gRow
    for (genvar go = 0; go < NPORT; go++) begin : gCol
      assign grantFlat[gi*NPORT+go] = gVal[go] && (gIdx[go] == IDXW'(gi));

      assert_grant_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
        grantFlat[gi*NPORT+go] |-> $past(reqFlat[gi*NPORT+go], 2));
    end
  end

  for (genvar go = 0; go < NPORT; go++) begin : gOut
    assert_oos_grant_R7: assert property (@(posedge clk) disable iff (rst)
      (oosQ[go] && |colVec[go]) |=> (gVal[go] && $stable(ptr[go])));

    assert_hold_keep_R5: assert property (@(posedge clk) disable iff (rst)
      (gVal[go] && colVec[go][gIdx[go]] && !brkQ[gIdx[go]] && !oosQ[go])
        |=> (gVal[go] && $stable(gIdx[go]) && $stable(ptr[go])));

    assert_idle_output_R8: assert property (@(posedge clk) disable iff (rst)
      !(|colVec[go]) |=> (!gVal[go] && $stable(ptr[go])));
  end
endmodule

// File: rtl/xbarCfgPipe.sv
module xbarCfgPipe
  import xbarArbPkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  arbStrobe_t           strobe,
  input  logic [DLYW-1:0]      delayD,
  output logic [NPORT-1:0]     cfgValid,
  output logic [NPORT*IDXW-1:0] cfgSelFlat
);
  arbStrobe_t srStage [SRDEPTH];
  logic [DLYW-1:0] tapIdx;
  arbStrobe_t tapVal;
  logic [IDXW-1:0] cfgSel [NPORT];

  assign tapIdx = (delayD < DLYW'(2)) ? '0 : delayD - DLYW'(2);
  assign tapVal = srStage[tapIdx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SRDEPTH; s++) srStage[s] <= '0;
    end else begin
      srStage[0] <= strobe;
      for (int s = 1; s < SRDEPTH; s++) srStage[s] <= srStage[s-1];
    end
  end

  for (genvar go = 0; go < NPORT; go++) begin : gCfg
    always_ff @(posedge clk) begin
      if (rst) begin
        cfgValid[go] <= 1'b0;
        cfgSel[go]   <= '0;
      end else if (tapVal.load[go]) begin
        cfgValid[go] <= 1'b1;
        cfgSel[go]   <= tapVal.sel[go];
      end
    end
    assign cfgSelFlat[go*IDXW +: IDXW] = cfgSel[go];

    assert_cfg_kept_R8: assert property (@(posedge clk) disable iff (rst)
      !$fell(cfgValid[go]));
  end

  assert_delay_range_R10: assert property (@(posedge clk) disable iff (rst)
    delayD >= DLYW'(2));
endmodule

// File: rtl/xbar_rr_arb.sv
module xbar_rr_arb
  import xbarArbPkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NREQ-1:0]       reqFlat,
  input  logic [NPORT-1:0]      brkIn,
  input  logic [NPORT-1:0]      oosIn,
  input  logic [DLYW-1:0]       delayD,
  output logic [NREQ-1:0]       grantFlat,
  output logic [NPORT-1:0]      cfgValid,
  output logic [NPORT*IDXW-1:0] cfgSelFlat
);
  arbStrobe_t strobe;

  xbarArbCtl uCtl (
    .clk(clk), .rst(rst), .reqFlat(reqFlat), .brkIn(brkIn), .oosIn(oosIn),
    .strobe(strobe), .grantFlat(grantFlat)
  );

  xbarCfgPipe uPipe (
    .clk(clk), .rst(rst), .strobe(strobe), .delayD(delayD),
    .cfgValid(cfgValid), .cfgSelFlat(cfgSelFlat)
  );
endmodule

// File: tb/tb_xbar_rr_arb.sv
module tb_xbar_rr_arb;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N*N-1:0] reqFlat = '0;
  logic [N-1:0] brkIn = '0;
  logic [N-1:0] oosIn = '0;
  logic [3:0] delayD = 4'd8;
  logic [N*N-1:0] grantFlat;
  logic [N-1:0] cfgValid;
  logic [N*4-1:0] cfgSelFlat;

  int checks = 0;
  int errors = 0;

  // reference state
  logic [N*N-1:0] mReqQ;
  logic [N-1:0] mBrk, mOos;
  int mVal[N], mIdx[N], mPtr[N];
  int hVal[N][N], hIdx[N][N];
  int cVal[N], cIdx[N];

  xbar_rr_arb dut (
    .clk(clk), .rst(rst), .reqFlat(reqFlat), .brkIn(brkIn), .oosIn(oosIn),
    .delayD(delayD), .grantFlat(grantFlat), .cfgValid(cfgValid), .cfgSelFlat(cfgSelFlat)
  );

  always #10 clk = ~clk;

  function automatic bit reqBit(int i, int o);
    return mReqQ[i*N+o];
  endfunction

  task automatic modelClear();
    mReqQ = '0; mBrk = '0; mOos = '0;
    for (int o = 0; o < N; o++) begin
      mVal[o] = 0; mIdx[o] = 0; mPtr[o] = 0; cVal[o] = 0; cIdx[o] = 0;
      for (int k = 0; k < N; k++) begin hVal[k][o] = 0; hIdx[k][o] = 0; end
    end
  endtask

  task automatic modelEdge();
    int nv[N]; int ni[N]; int any; int low; int w;
    if (rst) begin modelClear(); return; end
    for (int o = 0; o < N; o++) begin
      any = 0; low = 0;
      for (int i = N-1; i >= 0; i--) if (reqBit(i, o)) begin any = 1; low = i; end
      nv[o] = 0; ni[o] = mIdx[o];
      if (mOos[o] && any != 0) begin
        nv[o] = 1; ni[o] = low;
      end else if (mVal[o] != 0 && reqBit(mIdx[o], o) && !mBrk[mIdx[o]]) begin
        nv[o] = 1;
      end else if (any != 0) begin
        w = -1;
        for (int k = 0; k < N; k++)
          if (w < 0 && reqBit((mPtr[o]+k) % N, o)) w = (mPtr[o]+k) % N;
        nv[o] = 1; ni[o] = w; mPtr[o] = (w + 1) % N;
      end
    end
    for (int o = 0; o < N; o++) begin
      mVal[o] = nv[o]; mIdx[o] = ni[o];
      for (int k = N-1; k > 0; k--) begin hVal[k][o] = hVal[k-1][o]; hIdx[k][o] = hIdx[k-1][o]; end
      hVal[0][o] = nv[o]; hIdx[0][o] = ni[o];
      if (hVal[delayD][o] != 0) begin cVal[o] = 1; cIdx[o] = hIdx[delayD][o]; end
    end
    mReqQ = reqFlat; mBrk = brkIn; mOos = oosIn;
  endtask

  task automatic checkAll(string tag);
    logic [N*N-1:0] eg; logic [N-1:0] ev; logic [N*4-1:0] es;
    eg = '0; ev = '0; es = '0;
    for (int o = 0; o < N; o++) begin
      if (mVal[o] != 0) eg[mIdx[o]*N+o] = 1'b1;
      ev[o] = (cVal[o] != 0);
      es[o*4 +: 4] = 4'(cIdx[o]);
    end
    checks++;
    if (grantFlat !== eg) begin
      errors++;
      $display("FAIL %s grant actual=%h expected=%h", tag, grantFlat, eg);
    end
    checks++;
    if (cfgValid !== ev || cfgSelFlat !== es) begin
      errors++;
      $display("FAIL R9 (%s) cfg actual=%h/%h expected=%h/%h", tag, cfgValid, cfgSelFlat, ev, es);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    @(negedge clk);
    modelEdge();
    checkAll(tag);
  endtask

  task automatic doReset(logic [3:0] d);
    rst = 1'b1; reqFlat = '0; brkIn = '0; oosIn = '0; delayD = d;
    tick("R1"); tick("R1");
    rst = 1'b0;
  endtask

  task automatic randomRun(int cycles, string tag);
    for (int c = 0; c < cycles; c++) begin
      for (int i = 0; i < N; i++)
        reqFlat[i*N +: N] = N'($urandom & $urandom & $urandom);
      brkIn = N'($urandom);
      oosIn = N'($urandom & $urandom & $urandom);
      tick(tag);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    modelClear();
    doReset(4'd8);
    checks++;
    if (grantFlat !== '0 || cfgValid !== '0) begin
      errors++;
      $display("FAIL R1 reset actual=%h/%h expected=0/0", grantFlat, cfgValid);
    end

    // R2: two-cycle latency
    reqFlat[5*N+3] = 1'b1; brkIn = '1;
    tick("R2");
    checks++;
    if (grantFlat[5*N+3] !== 1'b0) begin
      errors++; $display("FAIL R2 early grant actual=1 expected=0");
    end
    reqFlat = '0;
    tick("R2");
    checks++;
    if (grantFlat[5*N+3] !== 1'b1) begin
      errors++; $display("FAIL R2 grant actual=%b expected=1", grantFlat[5*N+3]);
    end
    for (int c = 0; c < 10; c++) tick("R9");

    // R3: rotation over output 0
    reqFlat = '0; brkIn = '1;
    reqFlat[0*N+0] = 1'b1; reqFlat[1*N+0] = 1'b1; reqFlat[2*N+0] = 1'b1;
    for (int c = 0; c < 8; c++) tick("R3");

    // R5 / R11: multicast hold with break low
    reqFlat = '0; brkIn = '0; brkIn[6] = 1'b1;
    reqFlat[4*N +: N] = 16'h000F;
    reqFlat[6*N+1] = 1'b1;
    for (int c = 0; c < 6; c++) tick("R11");
    for (int c = 0; c < 4; c++) tick("R5");

    // R6: break high releases holding
    brkIn[4] = 1'b1;
    for (int c = 0; c < 6; c++) tick("R6");

    // R7: out-of-sync output 2, several requesters
    reqFlat = '0; brkIn = '0; oosIn[2] = 1'b1;
    reqFlat[9*N+2] = 1'b1; reqFlat[7*N+2] = 1'b1; reqFlat[12*N+2] = 1'b1;
    for (int c = 0; c < 5; c++) tick("R7");
    oosIn = '0;
    for (int c = 0; c < 4; c++) tick("R7");

    // R8: silence keeps configuration
    reqFlat = '0;
    for (int c = 0; c < 20; c++) tick("R8");

    randomRun(1000, "R4");
    doReset(4'd2);
    randomRun(400, "R10");
    doReset(4'd15);
    randomRun(400, "R10");
    reqFlat = '0;
    for (int c = 0; c < 20; c++) tick("R8");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule